// File: doc/BRIEF.md
# Printer Port Register Emulator

This block presents the byte-wide register set of a legacy printer port to a small host bus and plays the printer's side of the handshake internally, so host software can drive a complete print cycle with no device attached. Three registers are decoded from the low three address bits: a data register, a status register and a control register. A second 8-bit latch captures incoming data from an external port when a load strobe is pulsed. Host software selects which latch a data read returns through a direction bit in the control register.

A control write that raises the strobe bit sends the current output byte to a downstream sink as a one-cycle valid pulse. Each status read steps a simulated busy/acknowledge sequence. A control write that drops the strobe bit can raise a pending interrupt, and the interrupt output is a registered level that follows that pending state. A status read clears the pending state.

Top module: `lpt_regs`

## Requirements
- R1: Only address bits [2:0] are decoded. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. `rdata` is combinational with the access, and it is 0x00 when `rd_en` is low.
- R2: Every control write stores the written byte with bits 7 and 6 forced to 1. A read of the control register returns that stored value.
- R3: After reset, both data latches hold 0xFF, status is 0xD9, control is 0xCC, `irq` is 0 and `out_valid` is 0.
- R4: The status bits are: bit 7 not-busy, bit 6 ack, bit 5 paper-out, bit 4 online, bit 3 not-error, bit 0 timeout. The control bits are: bit 5 direction (1 = read), bit 4 interrupt enable, bit 3 select, bit 2 init (active low), bit 0 strobe. A control write with bit 2 at 0 sets status to 0xD8.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 1 clears status bit 7. If the stored strobe bit was 0 before that write, the next cycle shows `out_valid` high for exactly one cycle, with `out_data` equal to the output-data latch.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets interrupt-pending only when the previously stored control value has bit 4 set. `irq` goes high in the next cycle.
- R7: A status read returns the current status and clears interrupt-pending, so `irq` is 0 in the next cycle.
- R8: On a status read, if status bit 7 is 0 and the stored strobe bit is 0, the ack bit is updated. If ack was 1, it is cleared. Otherwise, both ack and bit 7 are set. In every other case the status read leaves status unchanged.
- R9: A data read returns the input-data latch when control bit 5 is 1, and the output-data latch when it is 0. A data write loads only the output-data latch.
- R10: When `in_load` is high at a clock edge, the input-data latch captures `in_data`.
- R11: A control write with bit 2 = 1 and bit 3 = 0 changes neither status nor interrupt-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Host address; only bits [2:0] are decoded |
| rd_en | input | 1 | Single-cycle host read |
| wr_en | input | 1 | Single-cycle host write |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the same cycle as `rd_en` |
| in_data | input | 8 | External input byte |
| in_load | input | 1 | Loads `in_data` into the input-data latch |
| out_data | output | 8 | Byte sent to the sink |
| out_valid | output | 1 | One-cycle pulse marking `out_data` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the host never raises `rd_en` and `wr_en` in the same cycle. Under that assumption, a status read and a control write never compete to update status or interrupt-pending. The stimulus picks exactly one access kind per cycle (read, write or idle), so this never happens, while `in_load` is driven independently. A behavioural model tracks every register through each access kind and is compared with `rdata`, `irq`, `out_valid` and `out_data` on every clock. This lets back-to-back strobe edges and repeated status reads in the ack sequence be checked as they occur.

// File: rtl/lpt_regs.sv
module lpt_regs #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [7:0]    in_data,
  input  logic          in_load,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          irq
);
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam int S_NBUSY = 7;
  localparam int S_ACK   = 6;
  localparam int C_DIR   = 5;
  localparam int C_IEN   = 4;
  localparam int C_SEL   = 3;
  localparam int C_INIT  = 2;
  localparam int C_STB   = 0;
  localparam logic [7:0] STAT_RST  = 8'hD9;
  localparam logic [7:0] STAT_INIT = 8'hD8;
  localparam logic [7:0] CTRL_RST  = 8'hCC;
  localparam logic [7:0] CTRL_FIX  = 8'hC0;

  logic [7:0] dout_q, din_q, stat_q, ctrl_q;
  logic       pend_q;
  logic [2:0] off;
  logic [7:0] ctrl_new;
  logic       ctrl_wr, stat_rd;

  assign off      = addr[2:0];
  assign ctrl_new = wdata | CTRL_FIX;
  assign ctrl_wr  = wr_en && off == OFF_CTRL;
  assign stat_rd  = rd_en && off == OFF_STAT;
  assign irq      = pend_q;

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      case (off)
        OFF_DATA: rdata = ctrl_q[C_DIR] ? din_q : dout_q;
        OFF_STAT: rdata = stat_q;
        OFF_CTRL: rdata = ctrl_q;
        default:  rdata = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= 8'hFF;
      din_q     <= 8'hFF;
      stat_q    <= STAT_RST;
      ctrl_q    <= CTRL_RST;
      pend_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'hFF;
    end else begin
      out_valid <= 1'b0;
      if (in_load) din_q <= in_data;
      if (stat_rd) begin
        pend_q <= 1'b0;
        if (!stat_q[S_NBUSY] && !ctrl_q[C_STB]) begin
          if (stat_q[S_ACK]) stat_q[S_ACK] <= 1'b0;
          else begin
            stat_q[S_ACK]   <= 1'b1;
            stat_q[S_NBUSY] <= 1'b1;
          end
        end
      end
      if (wr_en && off == OFF_DATA) dout_q <= wdata;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_new;
        if (!ctrl_new[C_INIT]) stat_q <= STAT_INIT;
        else if (ctrl_new[C_SEL]) begin
          if (ctrl_new[C_STB]) begin
            stat_q[S_NBUSY] <= 1'b0;
            if (!ctrl_q[C_STB]) begin
              out_valid <= 1'b1;
              out_data  <= dout_q;
            end
          end else if (ctrl_q[C_IEN]) begin
            pend_q <= 1'b1;
          end
        end
      end
    end
  end

  a_r2_ctrl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && off == OFF_CTRL |-> rdata[7:6] == 2'b11);

  a_r4_init_status: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !rd_en && !wdata[C_INIT] |=> stat_q == STAT_INIT);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(ctrl_wr && wdata[C_STB] && !ctrl_q[C_STB]));

  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_wr && !wdata[C_STB] && ctrl_q[C_IEN]));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !wr_en |=> !irq);
endmodule

// File: tb/lpt_regs_test.sv
module lpt_regs_test;
  localparam int PERIOD = 10;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic rd_en = 0, wr_en = 0, in_load = 0;
  logic [7:0] wdata = 0, in_data = 0;
  logic [7:0] rdata, out_data;
  logic out_valid, irq;

  int total = 0, bad = 0;
  bit done = 0;

  int m_dout = 8'hFF, m_din = 8'hFF, m_stat = 8'hD9, m_ctrl = 8'hCC;
  int m_pend = 0, m_ov = 0, m_od = 0;

  always #(PERIOD/2) clk = ~clk;

  lpt_regs #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .in_data(in_data), .in_load(in_load),
    .out_data(out_data), .out_valid(out_valid), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int exp_read(input bit r, input int a);
    if (!r) return 0;
    case (a & 7)
      0: return (m_ctrl & 8'h20) ? m_din : m_dout;
      1: return m_stat;
      2: return m_ctrl;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_step(input bit r, input bit w, input int a, input int d,
                            input bit ld, input int ind);
    int v;
    m_ov = 0;
    if (ld) m_din = ind;
    if (r && (a & 7) == 1) begin
      m_pend = 0;
      if (!(m_stat & 8'h80) && !(m_ctrl & 1)) begin
        if (m_stat & 8'h40) m_stat = m_stat & 8'hBF;
        else m_stat = m_stat | 8'hC0;
      end
    end
    if (w && (a & 7) == 0) m_dout = d;
    if (w && (a & 7) == 2) begin
      v = d | 8'hC0;
      if (!(v & 4)) m_stat = 8'hD8;
      else if (v & 8) begin
        if (v & 1) begin
          m_stat = m_stat & 8'h7F;
          if (!(m_ctrl & 1)) begin m_ov = 1; m_od = m_dout; end
        end else if (m_ctrl & 8'h10) m_pend = 1;
      end
      m_ctrl = v;
    end
  endtask

  task automatic cyc(input bit r, input bit w, input int a, input int d,
                     input bit ld, input int ind, input string tag);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a[AW-1:0]; wdata = d[7:0];
    in_load = ld; in_data = ind[7:0];
    #1;
    check({tag, " rdata"}, rdata, exp_read(r, a));
    @(posedge clk);
    model_step(r, w, a, d, ld, ind);
    #1;
    check({tag, " irq"}, irq, m_pend);
    check({tag, " out_valid"}, out_valid, m_ov);
    if (m_ov) check({tag, " out_data"}, out_data, m_od);
  endtask

  task automatic rd(input int a, input string tag); cyc(1, 0, a, 0, 0, 0, tag); endtask
  task automatic wr(input int a, input int d, input string tag); cyc(0, 1, a, d, 0, 0, tag); endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R3 irq", irq, 0);
    check("R3 out_valid", out_valid, 0);
    @(negedge clk); rst_n = 1;
    rd(0, "R3 data");
    rd(1, "R3 status");
    rd(2, "R3 ctrl");
    for (int k = 3; k < 8; k++) rd(k, "R1 unmapped");
    rd(4'b1010, "R1 alias ctrl");
    rd(4'b1011, "R1 alias unmapped");
    wr(2, 8'h00, "R4 init low");
    rd(2, "R2 fixed bits");
    rd(1, "R4 status");
    wr(0, 8'h5A, "R9 data write");
    wr(2, 8'h0C, "R6 strobe low no ien");
    wr(2, 8'h0D, "R5 strobe edge");
    wr(2, 8'h0D, "R5 strobe held");
    wr(2, 8'h0C, "R5 strobe drop");
    rd(1, "R8 ack clear");
    rd(1, "R8 ack set");
    rd(1, "R8 busy hold");
    wr(2, 8'h1C, "R6 ien set");
    wr(2, 8'h1C, "R6 pending");
    rd(0, "R9 read out latch");
    wr(2, 8'h14, "R11 select low");
    rd(1, "R7 status clears");
    cyc(0, 0, 0, 0, 1, 8'h3C, "R10 load");
    wr(2, 8'h2C, "R9 dir read");
    rd(0, "R9 read in latch");
    wr(0, 8'h77, "R9 write in dir read");
    rd(0, "R9 in latch kept");
    for (int n = 0; n < 3000; n++) begin
      int op, a, d;
      op = $urandom_range(0, 4);
      a  = $urandom_range(0, 15);
      d  = $urandom_range(0, 255);
      if (op == 3 || op == 4) a = (a & 8) | (op == 3 ? 2 : 1);
      case (op)
        0: cyc(1, 0, a, 0, $urandom_range(0, 1), $urandom_range(0, 255), "R1 random read");
        1: cyc(0, 1, a, d, $urandom_range(0, 1), $urandom_range(0, 255), "R9 random write");
        2: cyc(0, 0, a, d, $urandom_range(0, 1), $urandom_range(0, 255), "R10 random idle");
        3: cyc(0, 1, a, d | 8'h0C, 0, 0, "R5 random ctrl");
        default: cyc(1, 0, a, 0, 0, 0, "R8 random status");
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule